// File: doc/BRIEF.md
# Sixteen-Bit Command/Status Serial Slave

This block is the serial front end of a multi-channel driver controller. A host lowers the chip-select line and clocks in a 16-bit command word. In the same frame the block shifts out one of two 16-bit status words supplied in parallel by the surrounding logic. The first serial bit is the least significant bit of the command. It picks both targets: which of the two command registers is written and which of the two status words is returned.

The select line, serial clock and data input are brought into a fast system clock domain through synchronisers, and all edge detection happens there. A command is committed only when the frame carries exactly sixteen serial clocks. When it is, the block pulses a one-cycle commit strobe with the register index. It also pulses a status-clear request when the top bit of the word is set. Each command register exposes eight driver enables and a three-bit current-monitor select.

Top module: `spi_cmd_slave`

## Requirements
- R1: `do_oe_o` is low while the synchronised select line is high and high while it is low; it is 0 after reset.
- R2: After the select line falls and before any serial clock edge, `do_o` equals bit 0 of `stat0_i`, the fault bit.
- R3: The first rising serial clock edge of a frame loads the status word chosen by the incoming bit (0 selects `stat0_i`, 1 selects `stat1_i`) into the output shifter, so `do_o` shows bit 0 of that word.
- R4: Data input is sampled on rising serial edges, least significant bit first; after the k-th falling edge `do_o` presents bit k of the chosen status word (k = 1..15).
- R5: Bit 0 of a committed word selects the command register: 0 writes register 0, 1 writes register 1; the other register keeps its value.
- R6: On the rising edge of the select line a word is committed only if exactly 16 rising serial edges occurred; frames of 0..15 or more than 16 bits (including 32) leave both registers unchanged and raise no strobe.
- R7: Of a committed word, bits 8..1 drive the driver-enable outputs (bit 1 to enable 0) and bits 11..9 the monitor-select outputs.
- R8: `clr_req_o` pulses for one cycle, together with `commit_o`, when a committed word has bit 15 set, and never otherwise.
- R9: `commit_o` is a single-cycle pulse per valid frame, with `commit_idx_o` equal to the word's bit 0, aligned with the register update.
- R10: After reset both command registers are zero and no strobe is active.
- R11: Serial clock edges while the select line is high have no effect on the bit count or on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| stat0_i | input | 16 | Status word 0, bit 0 is the fault bit |
| stat1_i | input | 16 | Status word 1 |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for the data-out pad |
| drv_en0_o | output | 8 | Driver enables of command register 0 |
| mon_sel0_o | output | 3 | Monitor select of command register 0 |
| drv_en1_o | output | 8 | Driver enables of command register 1 |
| mon_sel1_o | output | 3 | Monitor select of command register 1 |
| commit_o | output | 1 | One-cycle strobe on a valid frame |
| commit_idx_o | output | 1 | Register index written by the commit |
| clr_req_o | output | 1 | One-cycle status-clear request |

## Verification
A corrupted bit counter shows up at the end of the frame. A valid frame then produces no commit and stale enables, or a short or long frame changes the outputs. A wrong readback select or shifter state shows on `do_o` within one serial half-period, because the bench compares every bit right after each rising edge. A stuck or mis-indexed bank register is visible on the enable and select outputs about ten system cycles after the select line rises.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int FRAME_BITS = 16;
    localparam int DRV_N      = 8;
    localparam int MON_W      = 3;
    localparam int NREG       = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CNT_MAX    = FRAME_BITS + 1;

    // Field placement is fixed by the serial format (bit 0 arrives first).
    typedef struct packed {
        logic             clr;
        logic [2:0]       spare;
        logic [MON_W-1:0] mon;
        logic [DRV_N-1:0] drv;
        logic             sel;
    } cmd_word_t;

    typedef struct packed {
        logic [DRV_N-1:0] drv;
        logic [MON_W-1:0] mon;
    } cmd_fields_t;

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
        return (c >= CNT_W'(CNT_MAX)) ? c : c + 1'b1;
    endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic a_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {(STAGES+1){RST_VAL}};
        else     sh <= {sh[STAGES-1:0], a_i};
    end

    assign lvl_o  = sh[STAGES-1];
    assign rise_o = sh[STAGES-1] & ~sh[STAGES];
    assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/spi_frame_core.sv
module spi_frame_core
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  csn_lvl,
    input  logic                  csn_rise,
    input  logic                  csn_fall,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  di_lvl,
    input  logic [FRAME_BITS-1:0] stat0_i,
    input  logic [FRAME_BITS-1:0] stat1_i,
    output logic                  do_o,
    output logic                  do_oe_o,
    output logic                  ok_o,
    output cmd_word_t             word_o
);
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] in_sh;
    logic [FRAME_BITS-1:0] out_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            in_sh   <= '0;
            out_sh  <= '0;
            do_oe_o <= 1'b0;
            ok_o    <= 1'b0;
        end else begin
            do_oe_o <= ~csn_lvl;
            ok_o    <= 1'b0;
            if (csn_fall) begin
                cnt    <= '0;
                out_sh <= stat0_i;
            end else if (csn_rise) begin
                ok_o <= (cnt == CNT_W'(FRAME_BITS));
                cnt  <= '0;
            end else if (!csn_lvl) begin
                if (sck_rise) begin
                    in_sh <= {di_lvl, in_sh[FRAME_BITS-1:1]};
                    cnt   <= cnt_step(cnt);
                    if (cnt == '0) out_sh <= di_lvl ? stat1_i : stat0_i;
                end else if (sck_fall && cnt != '0) begin
                    out_sh <= {1'b0, out_sh[FRAME_BITS-1:1]};
                end
            end
        end
    end

    assign do_o   = out_sh[0];
    assign word_o = cmd_word_t'(in_sh);
endmodule

// File: rtl/spi_cmd_bank.sv
module spi_cmd_bank
    import spi_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ok_i,
    input  cmd_word_t   word_i,
    output cmd_fields_t regs_o [NREG],
    output logic        commit_o,
    output logic        commit_idx_o,
    output logic        clr_req_o
);
    logic unused_spare;
    assign unused_spare = ^word_i.spare;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[g] <= '0;
            else if (ok_i && int'(word_i.sel) == g)
                regs_o[g] <= '{drv: word_i.drv, mon: word_i.mon};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_o     <= 1'b0;
            commit_idx_o <= 1'b0;
            clr_req_o    <= 1'b0;
        end else begin
            commit_o  <= ok_i;
            clr_req_o <= ok_i & word_i.clr;
            if (ok_i) commit_idx_o <= word_i.sel;
        end
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  csn_i,
    input  logic                  sclk_i,
    input  logic                  di_i,
    input  logic [FRAME_BITS-1:0] stat0_i,
    input  logic [FRAME_BITS-1:0] stat1_i,
    output logic                  do_o,
    output logic                  do_oe_o,
    output logic [DRV_N-1:0]      drv_en0_o,
    output logic [MON_W-1:0]      mon_sel0_o,
    output logic [DRV_N-1:0]      drv_en1_o,
    output logic [MON_W-1:0]      mon_sel1_o,
    output logic                  commit_o,
    output logic                  commit_idx_o,
    output logic                  clr_req_o
);
    logic csn_lvl, csn_rise, csn_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic di_lvl,  di_rise,  di_fall;
    logic ok;
    cmd_word_t   word;
    cmd_fields_t regs [NREG];
    logic unused_edges;

    assign unused_edges = sck_lvl ^ di_rise ^ di_fall;

    spi_sync_edge #(.STAGES(2), .RST_VAL(1'b1)) u_csn (
        .clk(clk), .rst(rst), .a_i(csn_i),
        .lvl_o(csn_lvl), .rise_o(csn_rise), .fall_o(csn_fall));
    spi_sync_edge #(.STAGES(2), .RST_VAL(1'b0)) u_sck (
        .clk(clk), .rst(rst), .a_i(sclk_i),
        .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));
    spi_sync_edge #(.STAGES(2), .RST_VAL(1'b0)) u_di (
        .clk(clk), .rst(rst), .a_i(di_i),
        .lvl_o(di_lvl), .rise_o(di_rise), .fall_o(di_fall));

    spi_frame_core u_core (
        .clk(clk), .rst(rst),
        .csn_lvl(csn_lvl), .csn_rise(csn_rise), .csn_fall(csn_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .di_lvl(di_lvl),
        .stat0_i(stat0_i), .stat1_i(stat1_i),
        .do_o(do_o), .do_oe_o(do_oe_o), .ok_o(ok), .word_o(word));

    spi_cmd_bank u_bank (
        .clk(clk), .rst(rst), .ok_i(ok), .word_i(word), .regs_o(regs),
        .commit_o(commit_o), .commit_idx_o(commit_idx_o), .clr_req_o(clr_req_o));

    assign drv_en0_o  = regs[0].drv;
    assign mon_sel0_o = regs[0].mon;
    assign drv_en1_o  = regs[1].drv;
    assign mon_sel1_o = regs[1].mon;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       do_oe_o,
    input logic       commit_o,
    input logic       commit_idx_o,
    input logic       clr_req_o,
    input logic [7:0] drv_en0_o,
    input logic [7:0] drv_en1_o,
    input logic [2:0] mon_sel0_o,
    input logic [2:0] mon_sel1_o
);
    // R1 / R6: a commit only happens once the frame has closed
    assert_commit_after_close_R1: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> !do_oe_o);
    // R9: strobe lasts exactly one cycle
    assert_commit_single_R9: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);
    // R8: clear request only with a commit
    assert_clr_with_commit_R8: assert property (@(posedge clk) disable iff (rst)
        clr_req_o |-> commit_o);
    // R5: register 0 changes only on a commit to index 0
    assert_reg0_guard_R5: assert property (@(posedge clk) disable iff (rst)
        !($stable(drv_en0_o) && $stable(mon_sel0_o)) |-> (commit_o && !commit_idx_o));
    // R5: register 1 changes only on a commit to index 1
    assert_reg1_guard_R5: assert property (@(posedge clk) disable iff (rst)
        !($stable(drv_en1_o) && $stable(mon_sel1_o)) |-> (commit_o && commit_idx_o));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk(clk), .rst(rst), .do_oe_o(do_oe_o), .commit_o(commit_o),
    .commit_idx_o(commit_idx_o), .clr_req_o(clr_req_o),
    .drv_en0_o(drv_en0_o), .drv_en1_o(drv_en1_o),
    .mon_sel0_o(mon_sel0_o), .mon_sel1_o(mon_sel1_o));

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic csn = 1'b1, sclk = 1'b0, di = 1'b0;
    logic [15:0] stat0 = '0, stat1 = '0;
    logic do_o, do_oe, commit, commit_idx, clr_req;
    logic [7:0] drv0, drv1;
    logic [2:0] mon0, mon1;

    int n_tests = 0, n_fail = 0;
    int n_commit = 0, n_clr = 0;
    logic [10:0] m_reg [2];

    spi_cmd_slave dut (
        .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .di_i(di),
        .stat0_i(stat0), .stat1_i(stat1), .do_o(do_o), .do_oe_o(do_oe),
        .drv_en0_o(drv0), .mon_sel0_o(mon0), .drv_en1_o(drv1), .mon_sel1_o(mon1),
        .commit_o(commit), .commit_idx_o(commit_idx), .clr_req_o(clr_req));

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (!rst) begin
        if (commit)  n_commit++;
        if (clr_req) n_clr++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [10:0] fields(input logic [15:0] w);
        return {w[8:1], w[11:9]};
    endfunction

    task automatic frame(input int nbits, input logic [31:0] word);
        logic [15:0] sel;
        int c0, k0;
        c0 = n_commit; k0 = n_clr;
        sel = word[0] ? stat1 : stat0;
        csn = 1'b0;
        wait_clk(HALF);
        check("R1 oe during frame", do_oe, 1);
        if (nbits > 0) check("R2 fault bit before clock", do_o, stat0[0]);
        for (int i = 0; i < nbits; i++) begin
            di = word[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            if (i == 0) check("R3 first bit of chosen status", do_o, sel[0]);
            else if (i < 16) check("R4 shifted status bit", do_o, sel[i]);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(HALF);
        check("R1 oe idle", do_oe, 0);
        if (nbits == 16) begin
            m_reg[word[0]] = fields(word[15:0]);
            check("R9 one commit", n_commit - c0, 1);
            check("R8 clear pulse", n_clr - k0, {31'b0, word[15]});
            check("R9 commit index", commit_idx, word[0]);
        end else begin
            check("R6 rejected frame no commit", n_commit - c0, 0);
        end
        check("R5 R7 reg0 fields", {drv0, mon0}, m_reg[0]);
        check("R5 R7 reg1 fields", {drv1, mon1}, m_reg[1]);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_reg[0] = '0; m_reg[1] = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R10 reset state
        check("R10 reset reg0", {drv0, mon0}, 0);
        check("R10 reset reg1", {drv1, mon1}, 0);
        check("R10 reset strobes", {commit, clr_req}, 0);
        check("R1 oe after reset", do_oe, 0);

        stat0 = 16'hA5C3; stat1 = 16'h3C5A;
        frame(16, 32'h0000_81FE);   // reg0, all enables, clear request
        frame(16, 32'h0000_0E03);   // reg1
        // R11 serial clocks with select high are ignored
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
        end
        check("R11 idle clocks no commit", {drv0, mon0, drv1, mon1}, {m_reg[0], m_reg[1]});
        stat0 = 16'h0F0E; stat1 = 16'hF0F1;
        frame(16, 32'h0000_0554);   // must still commit after idle clocks
        frame(15, 32'h0000_7FFE);   // R6 short
        frame(17, 32'h0001_7FFF);   // R6 long
        frame(32, 32'hFFFF_FFFF);   // R6 saturating count
        frame(0,  32'h0);           // R6 empty
        for (int n = 0; n < 30; n++) begin
            int nb;
            logic [31:0] w;
            stat0 = 16'($urandom); stat1 = 16'($urandom);
            w = $urandom;
            nb = (n % 3 == 0) ? int'($urandom_range(20, 0)) : 16;
            frame(nb, w);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule